// File: doc/BRIEF.md
# Serial display data loader

This block takes display and control information from a host over a three-wire synchronous serial link. The three wires are an active-low select, a data line and a shift clock. It samples the data line on each rising shift clock edge and collects eight samples into a byte. Each completed byte is steered by a byte index to one of four digit registers, or, for the fifth byte of a transfer, to a control register. The control register holds four special-segment bits, a cascade mode and a synchronisation bit. All latched values hold until they are overwritten, so the host does not need to refresh them.

The serial inputs are asynchronous to the system clock. They pass through a two-flop synchronizer before any edge is detected. Each falling edge of select starts a new transfer. The host may stop after any whole byte. Digit registers that received no byte in a transfer keep what they held before. The mode field is decoded into a stand-alone, master or slave selection. The one unused code falls back to stand-alone and sets a sticky error flag.

Top module: `lcd_serial_loader`

## Requirements
- R1: After reset the digit outputs, special segments and sync bit are all zero, the mode is stand-alone (code 00), and the error flag and done strobe are low.
- R2: A falling edge on sel_n clears the bit and byte counters, so the next eight bits always form byte one of a new transfer.
- R3: Within a digit byte the first bit shifted in lands at bit 7 (segment H) and the eighth bit at bit 0 (segment A), so the serial order is MSB first.
- R4: Completed bytes one to four of a transfer are written to digits_o[7:0], [15:8], [23:16] and [31:24] in that order.
- R5: In the fifth byte the first four bits shifted in go to spec_o[0] to spec_o[3]. The fifth bit is ignored. The sixth bit is Q6, the seventh is Q7 and the eighth drives sync_o.
- R6: mode_o encodes {Q7,Q6}: 1,1 gives slave (10), 0,1 gives stand-alone (00) and 0,0 gives master (01). mode_o never takes the value 11.
- R7: {Q7,Q6} = 1,0 gives stand-alone and sets err_o. err_o stays high until reset, even after legal modes are loaded later.
- R8: A transfer that ends after fewer than five bytes updates only the registers for the bytes it delivered; all others keep their contents.
- R9: A byte left incomplete when sel_n rises is discarded and changes no register.
- R10: Bytes after the fifth in one transfer change no register and produce no strobe.
- R11: load_done_o pulses high for exactly one cycle each time a fifth byte is latched.
- R12: While sel_n is high, activity on sclk and sdat changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdat | input | 1 | Serial data, sampled on rising sclk |
| digits_o | output | NDIG*8 | Digit registers, digit k in bits [8k+7:8k] |
| spec_o | output | 4 | Special-segment bits |
| mode_o | output | 2 | Cascade mode: 00 stand-alone, 01 master, 10 slave |
| sync_o | output | 1 | Synchronisation bit |
| err_o | output | 1 | Sticky flag for the unused mode code |
| load_done_o | output | 1 | One-cycle strobe when the control byte is latched |

## Verification
The bench builds the block with its default of four digits and the fixed eight-bit byte. At that size, every one of the 256 values can be swept through a digit byte, and separately through the control byte, each as a full five-byte transfer. This reaches every mode code, every special-segment combination and the onset and persistence of the sticky error. Directed transfers cover truncated bytes, over-long transfers, short transfers and idle clocking with select high.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

  localparam int BYTE_W = 8;

  // bit positions inside the control byte (first bit shifted in ends at bit 7)
  localparam int SP_FIRST_POS = 7;
  localparam int Q6_POS       = 2;
  localparam int Q7_POS       = 1;
  localparam int SYNC_POS     = 0;
  localparam int SPEC_W       = 4;

  typedef enum logic [1:0] {
    MODE_ALONE  = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10
  } lcd_mode_e;

  function automatic lcd_mode_e decode_mode(input logic q7, input logic q6);
    case ({q7, q6})
      2'b11:   return MODE_SLAVE;
      2'b00:   return MODE_MASTER;
      default: return MODE_ALONE;
    endcase
  endfunction

endpackage

// File: rtl/lcdl_sync.sv
module lcdl_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-W-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/lcdl_shifter.sv
module lcdl_shifter
  import lcdl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              frame_start,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_prev_q, sel_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              start_q, start_d;
  logic              rise, sel_fall, active;
  logic [BYTE_W-1:0] sr_shift;

  assign rise     = sclk_s & ~sclk_prev_q;
  assign sel_fall = sel_prev_q & ~sel_s;
  assign active   = ~sel_s;
  assign sr_shift = {sr_q[BYTE_W-2:0], sdat_s};

  always_comb begin
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    vld_d   = 1'b0;
    out_d   = out_q;
    start_d = sel_fall;
    if (sel_fall || !active) begin
      cnt_d = '0;
    end else if (rise) begin
      sr_d = sr_shift;
      if (cnt_q == CNT_W'(BYTE_W - 1)) begin
        cnt_d = '0;
        vld_d = 1'b1;
        out_d = sr_shift;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b1;
      cnt_q       <= '0;
      sr_q        <= '0;
      vld_q       <= 1'b0;
      out_q       <= '0;
      start_q     <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      sel_prev_q  <= sel_s;
      cnt_q       <= cnt_d;
      sr_q        <= sr_d;
      vld_q       <= vld_d;
      out_q       <= out_d;
      start_q     <= start_d;
    end
  end

  assign frame_start = start_q;
  assign byte_vld    = vld_q;
  assign byte_q      = out_q;
endmodule

// File: rtl/lcdl_bank.sv
module lcdl_bank
  import lcdl_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   byte_vld,
  input  logic [BYTE_W-1:0]      byte_q,
  output logic [NDIG*BYTE_W-1:0] digits_o,
  output logic [SPEC_W-1:0]      spec_o,
  output logic [1:0]             mode_o,
  output logic                   sync_o,
  output logic                   err_o,
  output logic                   load_done_o
);
  localparam int IDX_MAX = NDIG + 1;
  localparam int IDX_W   = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] dig_q [NDIG];
  logic              ctrl_we;
  logic [SPEC_W-1:0] spec_q, spec_d;
  lcd_mode_e         mode_q, mode_d;
  logic              sync_q, sync_d;
  logic              err_q, err_d;
  logic              done_q, done_d;

  assign ctrl_we = byte_vld && (idx_q == IDX_W'(NDIG));

  always_comb begin
    idx_d = idx_q;
    if (frame_start)                                idx_d = '0;
    else if (byte_vld && idx_q != IDX_W'(IDX_MAX))  idx_d = idx_q + 1'b1;
  end

  always_comb begin
    spec_d = spec_q;
    mode_d = mode_q;
    sync_d = sync_q;
    err_d  = err_q;
    done_d = ctrl_we;
    if (ctrl_we) begin
      for (int i = 0; i < SPEC_W; i++) spec_d[i] = byte_q[SP_FIRST_POS - i];
      mode_d = decode_mode(byte_q[Q7_POS], byte_q[Q6_POS]);
      sync_d = byte_q[SYNC_POS];
      err_d  = err_q | (byte_q[Q7_POS] & ~byte_q[Q6_POS]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      spec_q <= '0;
      mode_q <= MODE_ALONE;
      sync_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      spec_q <= spec_d;
      mode_q <= mode_d;
      sync_q <= sync_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_digit
      logic dig_we;
      assign dig_we = byte_vld && (idx_q == IDX_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dig_q[k] <= '0;
        else if (dig_we) dig_q[k] <= byte_q;
      end
      assign digits_o[k*BYTE_W +: BYTE_W] = dig_q[k];
    end
  endgenerate

  assign spec_o      = spec_q;
  assign mode_o      = mode_q;
  assign sync_o      = sync_q;
  assign err_o       = err_q;
  assign load_done_o = done_q;
endmodule

// File: rtl/lcd_serial_loader.sv
module lcd_serial_loader
  import lcdl_pkg::*;
#(
  parameter int NDIG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n,
  input  logic                   sclk,
  input  logic                   sdat,
  output logic [NDIG*BYTE_W-1:0] digits_o,
  output logic [SPEC_W-1:0]      spec_o,
  output logic [1:0]             mode_o,
  output logic                   sync_o,
  output logic                   err_o,
  output logic                   load_done_o
);
  logic [2:0]        pins_s;
  logic              frame_start, byte_vld;
  logic [BYTE_W-1:0] byte_q;

  lcdl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n, sclk, sdat}),
    .q     (pins_s)
  );

  lcdl_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .sdat_s      (pins_s[0]),
    .frame_start (frame_start),
    .byte_vld    (byte_vld),
    .byte_q      (byte_q)
  );

  lcdl_bank #(.NDIG(NDIG)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .byte_vld    (byte_vld),
    .byte_q      (byte_q),
    .digits_o    (digits_o),
    .spec_o      (spec_o),
    .mode_o      (mode_o),
    .sync_o      (sync_o),
    .err_o       (err_o),
    .load_done_o (load_done_o)
  );
endmodule

// File: rtl/lcdl_checker.sv
module lcdl_checker #(
  parameter int NDIG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic [NDIG*8-1:0] digits_o,
  input logic [3:0]        spec_o,
  input logic [1:0]        mode_o,
  input logic              sync_o,
  input logic              err_o,
  input logic              load_done_o
);
  logic [3:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idle_cnt <= '0;
    else if (!sel_n)             idle_cnt <= '0;
    else if (idle_cnt != 4'hF)   idle_cnt <= idle_cnt + 1'b1;
  end

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt >= 4'd10) |=> ($stable(digits_o) && $stable(spec_o) && $stable(mode_o)
                             && $stable(sync_o) && !load_done_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_done_o |=> !load_done_o);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);
endmodule

bind lcd_serial_loader lcdl_checker #(.NDIG(NDIG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_n       (sel_n),
  .digits_o    (digits_o),
  .spec_o      (spec_o),
  .mode_o      (mode_o),
  .sync_o      (sync_o),
  .err_o       (err_o),
  .load_done_o (load_done_o)
);

// File: tb/lcd_serial_loader_tb.sv
`timescale 1ns/1ps
module lcd_serial_loader_tb;
  localparam int NDIG = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_n, sclk, sdat;
  logic [NDIG*8-1:0] digits_o;
  logic [3:0] spec_o;
  logic [1:0] mode_o;
  logic sync_o, err_o, load_done_o;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lcd_serial_loader #(.NDIG(NDIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
    .digits_o(digits_o), .spec_o(spec_o), .mode_o(mode_o), .sync_o(sync_o),
    .err_o(err_o), .load_done_o(load_done_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && load_done_o) done_cnt <= done_cnt + 1;
    if (cyc == 190000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdat = b;  wait_clk(3);
    sclk = 1'b1; wait_clk(3);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic open_win();
    sel_n = 1'b0; wait_clk(4);
  endtask

  task automatic close_win();
    wait_clk(2); sel_n = 1'b1; wait_clk(12);
  endtask

  function automatic logic [1:0] exp_mode(input logic q7, input logic q6);
    if (q7 && q6)       return 2'b10;
    else if (!q7 && !q6) return 2'b01;
    else                return 2'b00;
  endfunction

  logic [7:0]  dexp [NDIG];
  logic [31:0] dig_all;
  logic [3:0]  sp_e;
  logic [1:0]  md_e;
  logic        sy_e, err_e;
  int          d0;

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdat = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk("R1 digits", digits_o, 0);
    chk("R1 spec", {28'd0, spec_o}, 0);
    chk("R1 mode", {30'd0, mode_o}, 0);
    chk("R1 sync", {31'd0, sync_o}, 0);
    chk("R1 err", {31'd0, err_o}, 0);
    chk("R1 done", {31'd0, load_done_o}, 0);

    // R3 / R8: single-byte transfers sweep all values through digit 1
    for (int v = 0; v < 256; v++) begin
      open_win(); send_byte(8'(v)); close_win();
      chk("R3 digit1 bit order", {24'd0, digits_o[7:0]}, v);
      chk("R8 other digits kept", {8'd0, digits_o[31:8]}, 0);
    end

    // R4 R5 R6 R7 R11: full transfers sweeping the control byte
    err_e = 1'b0;
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k < NDIG; k++) dexp[k] = 8'((c * 13 + k * 71 + 5) & 255);
      d0 = done_cnt;
      open_win();
      for (int k = 0; k < NDIG; k++) send_byte(dexp[k]);
      send_byte(8'(c));
      close_win();
      sp_e  = {c[4], c[5], c[6], c[7]};
      md_e  = exp_mode(c[1], c[2]);
      sy_e  = c[0];
      err_e = err_e | (c[1] & ~c[2]);
      dig_all = {dexp[3], dexp[2], dexp[1], dexp[0]};
      chk("R4 digit order", digits_o, dig_all);
      chk("R5 special segments", {28'd0, spec_o}, {28'd0, sp_e});
      chk("R5 sync", {31'd0, sync_o}, {31'd0, sy_e});
      chk("R6 mode decode", {30'd0, mode_o}, {30'd0, md_e});
      chk("R7 sticky error", {31'd0, err_o}, {31'd0, err_e});
      chk("R11 one strobe", done_cnt - d0, 1);
    end
    // last control byte 0xFF: slave, spec F, sync 1

    // R10: seven bytes, last two ignored
    d0 = done_cnt;
    open_win();
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    send_byte(8'h85);            // SP1=1, Q6=1, Q7=0, sync=1 -> stand-alone
    send_byte(8'hEE); send_byte(8'h02);
    close_win();
    chk("R10 digits", digits_o, 32'h44332211);
    chk("R10 spec", {28'd0, spec_o}, 32'h1);
    chk("R10 mode", {30'd0, mode_o}, 0);
    chk("R10 sync", {31'd0, sync_o}, 1);
    chk("R10 strobe count", done_cnt - d0, 1);

    // R9: incomplete byte discarded
    open_win(); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); close_win();
    chk("R9 partial byte discarded", digits_o, 32'h44332211);

    // R2: bits before select edge do not carry into the new transfer
    open_win(); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); close_win();
    open_win(); send_byte(8'h5A); close_win();
    chk("R2 counters restart", digits_o, 32'h4433225A);

    // R8: two-byte transfer keeps digits 3,4 and control
    d0 = done_cnt;
    open_win(); send_byte(8'hC3); send_byte(8'h3C); close_win();
    chk("R8 partial transfer", digits_o, 32'h44333CC3);
    chk("R8 control kept", {28'd0, spec_o}, 32'h1);
    chk("R8 no strobe", done_cnt - d0, 0);

    // R12: clocking with select high changes nothing
    d0 = done_cnt;
    for (int i = 0; i < 40; i++) send_bit(i[0]);
    wait_clk(12);
    chk("R12 digits held", digits_o, 32'h44333CC3);
    chk("R12 spec held", {28'd0, spec_o}, 32'h1);
    chk("R12 sync held", {31'd0, sync_o}, 1);
    chk("R12 no strobe", done_cnt - d0, 0);

    // R7: error stays set after legal modes, cleared by reset only
    chk("R7 err persists", {31'd0, err_o}, 1);
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(5);
    chk("R1 err after reset", {31'd0, err_o}, 0);
    chk("R1 digits after reset", digits_o, 0);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule